// File: doc/BRIEF.md
# CAM Host Cycle and Match-Lock Controller

This block sits between a host bus and a content-addressable match array. A host cycle begins when the active-low enable falls. At that instant the block takes the active-low write select and command select inputs and decides which of four cycle types is running. On a write it takes the 16-bit bus word. On a read it drives the bus for as long as the enable stays low. Command writes load the block's small set of control fields. Data writes go out to the array as strobed 16-bit segments.

A segment counter splits a wide word into one to four 16-bit transfers, running from a start count to an end count. When a data write to the comparand or mask register lands on the end count, the block issues a compare request by itself. The array returns a match and a multiple-match bit one clock later. The block latches them as flags.

For cascaded parts there is a daisy-chain lock. The cascade enable sampled at the start of one cycle sets the lock for the next cycle. While the lock is in effect and the last compare missed, the cycle is blocked. In standard mode, a blocked cycle can neither read nor write, so a cycle run with the cascade enable HIGH is needed to release the chain. In enhanced mode, blocked writes still proceed.

Top module: `cam_host_ctrl`

## Requirements
- R1: The cycle type is taken from {we_n, cmd_n} on the clock where en_n is first seen LOW: 2'b11 is a data read, 2'b10 a command read, 2'b01 a data write, 2'b00 a command write. Later changes on those inputs within the same cycle are ignored.
- R2: On an accepted data write, wr_stb is high for exactly one clock, starting the clock after the start edge. In that clock wr_word holds the dq_i value taken at the start edge, wr_dest holds the current destination and wr_seg holds the segment count in use.
- R3: dq_oe is high only while en_n is LOW in an unblocked read cycle, from the clock after the start edge. A data read drives assoc_i. A command read drives the status word: bit 0 is matched, bit 1 is multiple match, bit 2 is enhanced mode, bits 4:3 are the destination, bits 6:5 are the segment count, and all other bits are zero.
- R4: A command write decodes dq_i[15:12] as follows. 0 is a no-operation. 1 loads the segment start from dq_i[1:0] and the segment end from dq_i[3:2]. 2 loads the destination from dq_i[1:0], where 0 is comparand, 1 is mask and 2 is memory. 3 loads enhanced mode from dq_i[0].
- R5: Each accepted data write moves the segment count up by one. A write made at the end count reloads the start count. Loading the segment fields also resets the count to the new start.
- R6: A data write to the comparand or mask destination made at the end count raises cmp_req for one clock, together with wr_stb. A write to memory never raises cmp_req.
- R7: match_n and mult_n take the inverted match_i and multi_i one clock after cmp_req. They hold at all other times.
- R8: The cascade enable ec_n sampled at a cycle's start sets the lock that applies to the next cycle. A cycle is blocked when its lock is set and the last compare missed. A compare that matches leaves the next locked read unblocked.
- R9: In standard mode a blocked read leaves dq_oe LOW, and a blocked write has no effect: there is no wr_stb and no command update.
- R10: In enhanced mode a blocked read still leaves dq_oe LOW, but data and command writes proceed.
- R11: Any cycle run with ec_n HIGH, a no-operation included, removes the block from the cycle that follows it.
- R12: After reset, dq_oe, wr_stb and cmp_req are LOW, match_n and mult_n are HIGH, both segment counts are 0, the destination is comparand and the mode is standard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low cycle enable |
| we_n | input | 1 | Active-low write select |
| cmd_n | input | 1 | Active-low command select |
| ec_n | input | 1 | Active-low cascade enable |
| dq_i | input | 16 | Host bus input |
| dq_o | output | 16 | Host bus output value |
| dq_oe | output | 1 | Host bus output enable |
| assoc_i | input | 16 | Associated data from the array |
| match_i | input | 1 | Compare result: match |
| multi_i | input | 1 | Compare result: multiple match |
| wr_stb | output | 1 | Segment write strobe to the array |
| wr_dest | output | 2 | Destination of the segment write |
| wr_seg | output | 2 | Segment index of the write |
| wr_word | output | 16 | Segment data |
| cmp_req | output | 1 | Compare request to the array |
| match_n | output | 1 | Active-low match flag |
| mult_n | output | 1 | Active-low multiple-match flag |

## Verification
Data writes are run with a one-segment setting and with start-to-end windows of three segments. This separates a compare fired at the end count from one fired on every write, and a reload to the start count from a wrap to zero. Each destination is written in turn, so the memory case shows that a compare is never raised there. The lock is tried with ec_n LOW followed by a miss, by a hit, and with ec_n held HIGH. Reads and writes are run in both modes. Together these separate a cycle blocked only for reads from one blocked for everything, and show that the unlocking cycle must come first. A select input changed in the middle of a cycle shows that the type is fixed at the start edge.

// File: rtl/cam_host_pkg.sv
package cam_host_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int DST_W  = 2;

    // {we_n, cmd_n} as sampled at the start edge
    typedef enum logic [1:0] {
        CY_CMD_WR = 2'b00,
        CY_DAT_WR = 2'b01,
        CY_CMD_RD = 2'b10,
        CY_DAT_RD = 2'b11
    } cyc_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_SEG  = 4'd1,
        OP_DEST = 4'd2,
        OP_MODE = 4'd3
    } op_e;

    localparam logic [DST_W-1:0] DST_CMP = 2'd0;
    localparam logic [DST_W-1:0] DST_MSK = 2'd1;
    localparam logic [DST_W-1:0] DST_MEM = 2'd2;

    function automatic logic cyc_is_write(cyc_e c);
        return (c == CY_CMD_WR) || (c == CY_DAT_WR);
    endfunction

endpackage

// File: rtl/chc_cycle_capture.sv
module chc_cycle_capture
    import cam_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic we_n,
    input  logic cmd_n,
    output logic start_o,
    output cyc_e cyc_now_o,
    output logic act_o,
    output cyc_e cyc_o
);

    typedef struct packed {
        logic en_prev;
        logic act;
        cyc_e cyc;
    } cap_s;

    cap_s cap_d, cap_q;
    logic start_w;
    cyc_e cyc_w;

    always_comb begin
        cyc_w   = cyc_e'({we_n, cmd_n});
        start_w = cap_q.en_prev & ~en_n;
        cap_d   = cap_q;
        cap_d.en_prev = en_n;
        if (start_w) begin
            cap_d.act = 1'b1;
            cap_d.cyc = cyc_w;
        end else if (en_n) begin
            cap_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{en_prev: 1'b1, act: 1'b0, cyc: CY_DAT_RD};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign start_o   = start_w;
    assign cyc_now_o = cyc_w;
    assign act_o     = cap_q.act;
    assign cyc_o     = cap_q.cyc;

    AST_START_OPENS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> cap_q.act) else $error("start without active cycle"); // R1
    AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.act && !en_n) |=> $stable(cap_q.cyc)) else $error("cycle type moved"); // R1

endmodule

// File: rtl/chc_seg_ctrl.sv
module chc_seg_ctrl
    import cam_host_pkg::*;
#(
    parameter int SEG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  cyc_e              cyc_now_i,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              blk_now_i,
    output logic              wr_stb_o,
    output logic [DST_W-1:0]  wr_dest_o,
    output logic [SEG_W-1:0]  wr_seg_o,
    output logic [DATA_W-1:0] wr_word_o,
    output logic              cmp_req_o,
    output logic [DST_W-1:0]  dest_o,
    output logic [SEG_W-1:0]  cnt_o,
    output logic              enh_o
);

    localparam int OP_LSB = DATA_W - OP_W;

    typedef struct packed {
        logic [SEG_W-1:0]  seg_start;
        logic [SEG_W-1:0]  seg_end;
        logic [SEG_W-1:0]  cnt;
        logic [DST_W-1:0]  dest;
        logic              enh;
        logic              stb;
        logic [DST_W-1:0]  wdest;
        logic [SEG_W-1:0]  wseg;
        logic [DATA_W-1:0] word;
        logic              cmp;
    } seg_s;

    seg_s sg_d, sg_q;
    logic accept_w;
    op_e  op_w;

    always_comb begin
        sg_d     = sg_q;
        sg_d.stb = 1'b0;
        sg_d.cmp = 1'b0;
        op_w     = op_e'(dq_i[DATA_W-1:OP_LSB]);
        accept_w = start_i && cyc_is_write(cyc_now_i) && !(blk_now_i && !sg_q.enh);
        if (accept_w) begin
            if (cyc_now_i == CY_CMD_WR) begin
                case (op_w)
                    OP_SEG: begin
                        sg_d.seg_start = dq_i[SEG_W-1:0];
                        sg_d.seg_end   = dq_i[2*SEG_W-1:SEG_W];
                        sg_d.cnt       = dq_i[SEG_W-1:0];
                    end
                    OP_DEST: sg_d.dest = dq_i[DST_W-1:0];
                    OP_MODE: sg_d.enh  = dq_i[0];
                    default: ;
                endcase
            end else begin
                sg_d.stb   = 1'b1;
                sg_d.word  = dq_i;
                sg_d.wdest = sg_q.dest;
                sg_d.wseg  = sg_q.cnt;
                if (sg_q.cnt == sg_q.seg_end) begin
                    sg_d.cnt = sg_q.seg_start;
                    sg_d.cmp = (sg_q.dest == DST_CMP) || (sg_q.dest == DST_MSK);
                end else begin
                    sg_d.cnt = sg_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_q <= '0;
        end else begin
            sg_q <= sg_d;
        end
    end

    assign wr_stb_o  = sg_q.stb;
    assign wr_dest_o = sg_q.wdest;
    assign wr_seg_o  = sg_q.wseg;
    assign wr_word_o = sg_q.word;
    assign cmp_req_o = sg_q.cmp;
    assign dest_o    = sg_q.dest;
    assign cnt_o     = sg_q.cnt;
    assign enh_o     = sg_q.enh;

    AST_CMP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        sg_q.cmp |=> !sg_q.cmp) else $error("compare longer than one clock"); // R6
    AST_CMP_NOT_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
        sg_q.cmp |-> (sg_q.stb && sg_q.wdest != DST_MEM)) else $error("compare on memory write"); // R6
    AST_END_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        sg_q.cmp |-> (sg_q.cnt == sg_q.seg_start)) else $error("no reload at end count"); // R5

endmodule

// File: rtl/chc_lock_ctrl.sv
module chc_lock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ec_n,
    input  logic cmp_i,
    input  logic match_i,
    input  logic multi_i,
    output logic blk_now_o,
    output logic blk_o,
    output logic mf_o,
    output logic mm_o
);

    typedef struct packed {
        logic lock;
        logic miss;
        logic blk;
        logic mf;
        logic mm;
    } lk_s;

    lk_s lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (start_i) begin
            lk_d.lock = ~ec_n;
            lk_d.blk  = lk_q.lock & lk_q.miss;
        end
        if (cmp_i) begin
            lk_d.mf   = match_i;
            lk_d.mm   = multi_i;
            lk_d.miss = ~match_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign blk_now_o = lk_q.lock & lk_q.miss;
    assign blk_o     = lk_q.blk;
    assign mf_o      = lk_q.mf;
    assign mm_o      = lk_q.mm;

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_i |=> $stable({lk_q.mf, lk_q.mm})) else $error("flags moved without compare"); // R7
    AST_LOCK_FROM_EC: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (lk_q.lock == !$past(ec_n))) else $error("lock not taken from cascade enable"); // R8

endmodule

// File: rtl/cam_host_ctrl.sv
module cam_host_ctrl
    import cam_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_n,
    input  logic        we_n,
    input  logic        cmd_n,
    input  logic        ec_n,
    input  logic [15:0] dq_i,
    output logic [15:0] dq_o,
    output logic        dq_oe,
    input  logic [15:0] assoc_i,
    input  logic        match_i,
    input  logic        multi_i,
    output logic        wr_stb,
    output logic [1:0]  wr_dest,
    output logic [1:0]  wr_seg,
    output logic [15:0] wr_word,
    output logic        cmp_req,
    output logic        match_n,
    output logic        mult_n
);

    localparam int SEG_W   = 2;
    localparam int ST_CNT  = 5;
    localparam int ST_PAD  = DATA_W - ST_CNT - SEG_W;

    logic             start_w, act_w, blk_now_w, blk_w, mf_w, mm_w, enh_w;
    cyc_e             cyc_now_w, cyc_w;
    logic [DST_W-1:0] dest_w;
    logic [SEG_W-1:0] cnt_w;
    logic [DATA_W-1:0] status_w;
    logic             rd_cyc_w;

    chc_cycle_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n      (en_n),
        .we_n      (we_n),
        .cmd_n     (cmd_n),
        .start_o   (start_w),
        .cyc_now_o (cyc_now_w),
        .act_o     (act_w),
        .cyc_o     (cyc_w)
    );

    chc_seg_ctrl #(.SEG_W(SEG_W)) u_seg (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .cyc_now_i (cyc_now_w),
        .dq_i      (dq_i),
        .blk_now_i (blk_now_w),
        .wr_stb_o  (wr_stb),
        .wr_dest_o (wr_dest),
        .wr_seg_o  (wr_seg),
        .wr_word_o (wr_word),
        .cmp_req_o (cmp_req),
        .dest_o    (dest_w),
        .cnt_o     (cnt_w),
        .enh_o     (enh_w)
    );

    chc_lock_ctrl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .ec_n      (ec_n),
        .cmp_i     (cmp_req),
        .match_i   (match_i),
        .multi_i   (multi_i),
        .blk_now_o (blk_now_w),
        .blk_o     (blk_w),
        .mf_o      (mf_w),
        .mm_o      (mm_w)
    );

    always_comb begin
        status_w = {{ST_PAD{1'b0}}, cnt_w, dest_w, enh_w, mm_w, mf_w};
        rd_cyc_w = (cyc_w == CY_DAT_RD) || (cyc_w == CY_CMD_RD);
        dq_oe    = act_w && rd_cyc_w && !blk_w && !en_n;
        dq_o     = (cyc_w == CY_DAT_RD) ? assoc_i : status_w;
    end

    assign match_n = ~mf_w;
    assign mult_n  = ~mm_w;

    AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !en_n) else $error("bus driven with enable high"); // R3
    AST_STD_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && blk_now_w && !enh_w) |=> !wr_stb) else $error("blocked write reached array"); // R9
    AST_BLOCKED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        blk_w |-> !dq_oe) else $error("blocked read drove bus"); // R10

endmodule

// File: tb/sim_cam_host_ctrl.sv
module sim_cam_host_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_n = 1'b1, we_n = 1'b1, cmd_n = 1'b1, ec_n = 1'b1;
    logic [15:0] dq_i = '0, assoc_i = 16'hC3E1;
    logic        match_i = 1'b0, multi_i = 1'b0;
    logic [15:0] dq_o, wr_word;
    logic        dq_oe, wr_stb, cmp_req, match_n, mult_n;
    logic [1:0]  wr_dest, wr_seg;

    int checks = 0, errors = 0;
    logic done = 1'b0;

    logic        s_stb, s_cmp, s_oe, s_oe2;
    logic [15:0] s_word, s_do;
    logic [1:0]  s_dest, s_seg;

    always #5 clk = ~clk;

    cam_host_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .we_n(we_n), .cmd_n(cmd_n),
        .ec_n(ec_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .assoc_i(assoc_i),
        .match_i(match_i), .multi_i(multi_i), .wr_stb(wr_stb), .wr_dest(wr_dest),
        .wr_seg(wr_seg), .wr_word(wr_word), .cmp_req(cmp_req),
        .match_n(match_n), .mult_n(mult_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stat(input logic mf, mm, enh, input logic [1:0] dst, cnt);
        return {9'b0, cnt, dst, enh, mm, mf};
    endfunction

    // one host cycle; flip_we toggles we_n in the middle of the cycle
    task automatic cyc(input logic we, input logic cmd, input logic ecn,
                       input logic [15:0] d, input logic flip_we);
        @(negedge clk);
        en_n = 1'b0; we_n = we; cmd_n = cmd; ec_n = ecn; dq_i = d;
        @(posedge clk); #1;
        s_stb = wr_stb; s_word = wr_word; s_dest = wr_dest; s_seg = wr_seg; s_cmp = cmp_req;
        @(negedge clk);
        s_oe = dq_oe; s_do = dq_o;
        if (flip_we) begin we_n = ~we_n; dq_i = ~dq_i; end
        @(negedge clk);
        s_oe2 = dq_oe;
        en_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cmdw(input logic [3:0] op, input logic [11:0] arg, input logic ecn);
        cyc(1'b0, 1'b0, ecn, {op, arg}, 1'b0);
    endtask
    task automatic datw(input logic [15:0] d, input logic ecn);
        cyc(1'b0, 1'b1, ecn, d, 1'b0);
    endtask
    task automatic cmdr(input logic ecn);
        cyc(1'b1, 1'b0, ecn, 16'h0, 1'b0);
    endtask
    task automatic datr(input logic ecn);
        cyc(1'b1, 1'b1, ecn, 16'h0, 1'b0);
    endtask

    task automatic t_reset;
        chk("R12 dq_oe", dq_oe, 0);
        chk("R12 wr_stb", wr_stb, 0);
        chk("R12 cmp_req", cmp_req, 0);
        chk("R12 match_n", match_n, 1);
        chk("R12 mult_n", mult_n, 1);
        cmdr(1'b1);
        chk("R12 status", s_do, stat(0, 0, 0, 2'd0, 2'd0));
        chk("R3 cmd read drives", s_oe, 1);
    endtask

    task automatic t_single_write;
        match_i = 1'b1; multi_i = 1'b0;
        datw(16'hA5A5, 1'b1);
        chk("R2 stb", s_stb, 1);
        chk("R2 word", s_word, 16'hA5A5);
        chk("R2 dest", s_dest, 0);
        chk("R2 seg", s_seg, 0);
        chk("R6 cmp on comparand end", s_cmp, 1);
        chk("R7 match_n after hit", match_n, 0);
        chk("R7 mult_n", mult_n, 1);
        chk("R2 stb one clock", wr_stb, 0);
    endtask

    task automatic t_segments;
        cmdw(4'd2, 12'd1, 1'b1);                  // destination mask
        cmdw(4'd1, 12'h00D, 1'b1);                // start 1, end 3
        cmdr(1'b1);
        chk("R4 status dest/cnt", s_do, stat(1, 0, 0, 2'd1, 2'd1));
        datw(16'h1111, 1'b1);
        chk("R5 seg first", s_seg, 1); chk("R6 no cmp mid", s_cmp, 0);
        datw(16'h2222, 1'b1);
        chk("R5 seg second", s_seg, 2); chk("R6 no cmp mid2", s_cmp, 0);
        datw(16'h3333, 1'b1);
        chk("R5 seg end", s_seg, 3); chk("R6 cmp at end mask", s_cmp, 1);
        chk("R2 dest mask", s_dest, 1);
        datw(16'h4444, 1'b1);
        chk("R5 reload start", s_seg, 1);
        cmdw(4'd1, 12'h00D, 1'b1);                // counter back to start
        datw(16'h5555, 1'b1);
        chk("R5 seg write resets count", s_seg, 1);
    endtask

    task automatic t_memory;
        cmdw(4'd2, 12'd2, 1'b1);
        cmdw(4'd1, 12'h000, 1'b1);
        datw(16'h7777, 1'b1);
        chk("R6 memory stb", s_stb, 1);
        chk("R6 memory no cmp", s_cmp, 0);
        chk("R2 dest memory", s_dest, 2);
    endtask

    task automatic t_flags_and_decode;
        cmdw(4'd2, 12'd0, 1'b1);
        match_i = 1'b1; multi_i = 1'b1;
        datw(16'h0101, 1'b1);
        chk("R7 match_n hit", match_n, 0);
        chk("R7 mult_n multi", mult_n, 0);
        match_i = 1'b0; multi_i = 1'b0;
        cmdw(4'd2, 12'd2, 1'b1);
        datw(16'h0202, 1'b1);                     // memory write, no compare
        chk("R7 match_n held", match_n, 0);
        chk("R7 mult_n held", mult_n, 0);
        cyc(1'b1, 1'b1, 1'b1, 16'h0, 1'b1);       // data read, we_n flipped mid-cycle
        chk("R3 data read value", s_do, 16'hC3E1);
        chk("R1 read held after flip", s_oe2, 1);
        chk("R1 no write from flip", wr_stb, 0);
        cyc(1'b0, 1'b0, 1'b1, {4'd2, 12'd1}, 1'b1); // command write, flipped mid-cycle
        cmdr(1'b1);
        chk("R1 command applied once", s_do[4:3], 2'd1);
    endtask

    task automatic t_std_lock;
        cmdw(4'd2, 12'd0, 1'b1);
        match_i = 1'b0;
        datw(16'h0F0F, 1'b0);                     // miss, ec low
        chk("R7 match_n miss", match_n, 1);
        cmdr(1'b0);
        chk("R9 blocked read no drive", s_oe, 0);
        cmdw(4'd2, 12'd1, 1'b0);                  // blocked command
        datw(16'hBEEF, 1'b0);
        chk("R9 blocked data write no stb", s_stb, 0);
        cmdw(4'd0, 12'd0, 1'b1);                  // NOP with ec high
        cmdr(1'b1);
        chk("R11 read after unlock drives", s_oe, 1);
        chk("R9 blocked command ignored", s_do[4:3], 2'd0);
    endtask

    task automatic t_lock_hit;
        match_i = 1'b1;
        datw(16'h1234, 1'b0);
        datr(1'b0);
        chk("R8 locked read after hit drives", s_oe, 1);
        chk("R8 assoc value", s_do, 16'hC3E1);
    endtask

    task automatic t_enhanced;
        cmdw(4'd3, 12'd1, 1'b1);
        match_i = 1'b0;
        datw(16'h0A0A, 1'b0);                     // miss, lock next
        datr(1'b0);
        chk("R10 blocked read enhanced", s_oe, 0);
        datw(16'h0B0B, 1'b0);
        chk("R10 blocked write proceeds", s_stb, 1);
        chk("R10 write word", s_word, 16'h0B0B);
        cmdw(4'd2, 12'd1, 1'b1);                  // still blocked, ec high
        cmdr(1'b1);
        chk("R10 command proceeds", s_do, stat(0, 0, 1, 2'd1, 2'd0));
    endtask

    task automatic t_single_chip;
        cmdw(4'd3, 12'd0, 1'b1);
        cmdw(4'd2, 12'd0, 1'b1);
        match_i = 1'b0;
        datw(16'h5A5A, 1'b1);
        datr(1'b1);
        chk("R8 ec high miss not blocked", s_oe, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_write();
        t_segments();
        t_memory();
        t_flags_and_decode();
        t_std_lock();
        t_lock_hit();
        t_enhanced();
        t_single_chip();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule